// File: doc/BRIEF.md
# Flag-Based Branch Resolution Unit

This unit resolves the next program counter for every jump-class instruction of a 16-bit accumulator processor. It takes the decoded jump kind, a one-bit form selector, the flag byte, the accumulator, the sequential program counter, a 16-bit immediate and a return address popped elsewhere. It returns the next program counter and a taken indication, both purely combinational and valid in the same cycle as the inputs.

Each conditional kind tests the flag byte with its own condition. The greater-or-equal and less-or-equal conditions look only at zero and carry. The greater and less conditions compare sign with overflow. When a jump is taken, its target comes from the immediate or from the accumulator, as the form bit selects. Return always targets the supplied return address. An untaken or non-jump instruction passes the sequential program counter through, and that counter already points past any immediate the instruction consumed.

Top module: `br_resolve_unit`

## Requirements
- R1: Kind code 4 (equal) is taken exactly when the zero flag (flag bit 0) is 1.
- R2: Kind code 5 (not equal) is taken exactly when the zero flag is 0.
- R3: Kind code 6 (greater) is taken exactly when zero is 0 and sign (bit 2) equals overflow (bit 3).
- R4: Kind code 7 (greater or equal) is taken exactly when carry (bit 1) is 0, whatever the other flags hold.
- R5: Kind code 8 (less) is taken exactly when sign differs from overflow.
- R6: Kind code 9 (less or equal) is taken exactly when zero is 1 or carry is 1.
- R7: Kind codes 1 (jump) and 2 (call) are always taken. Kind code 3 (return) is always taken and its next PC is `ret_addr_i`, whatever the form bit is.
- R8: A taken jump, call or conditional jump goes to `imm_i` when `use_acc_i` is 0 and to `acc_i` when `use_acc_i` is 1.
- R9: When not taken, `next_pc_o` equals `seq_pc_i`.
- R10: Kind code 0 (no jump) and codes 10 to 15 are never taken.
- R11: Flag bits 4 to 7 have no effect on the taken indication or on the next PC.
- R12: The outputs follow an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 4 | Decoded jump kind code |
| use_acc_i | input | 1 | Target form: 0 immediate, 1 accumulator |
| flags_i | input | 8 | Flag byte (Z bit 0, C bit 1, S bit 2, O bit 3) |
| acc_i | input | 16 | Accumulator value |
| seq_pc_i | input | 16 | Address following the whole instruction |
| imm_i | input | 16 | Immediate target |
| ret_addr_i | input | 16 | Return address for the return kind |
| next_pc_o | output | 16 | Resolved next program counter |
| taken_o | output | 1 | High when control transfers |

## Verification
Every one of the 16 kind codes is applied with all 16 combinations of the four flag bits, and with both target forms. This separates the carry-only greater-or-equal from a sign-based one, and separates zero-or-carry less-or-equal from zero-or-sign-mismatch. Accumulator, immediate, sequential and return addresses always differ from one another, so a wrong target source shows up as a wrong address and not only as a wrong taken bit. Separate passes flip the upper flag nibble while the lower nibble is held, and change inputs with no clock edge in between.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int ADDR_W = 16;
  localparam int FLAG_W = 8;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    JK_NONE = 4'd0,
    JK_JMP  = 4'd1,
    JK_CALL = 4'd2,
    JK_RET  = 4'd3,
    JK_EQ   = 4'd4,
    JK_NE   = 4'd5,
    JK_GT   = 4'd6,
    JK_GE   = 4'd7,
    JK_LT   = 4'd8,
    JK_LE   = 4'd9
  } jkind_e;

  typedef struct packed {
    logic z;
    logic c;
    logic s;
    logic o;
  } flagset_t;

  function automatic logic flag_at(input logic [FLAG_W-1:0] fb, input int pos);
    return fb[pos];
  endfunction

  function automatic logic cond_holds(input jkind_e k, input flagset_t f);
    logic r;
    case (k)
      JK_JMP, JK_CALL, JK_RET: r = 1'b1;
      JK_EQ:                   r = f.z;
      JK_NE:                   r = !f.z;
      JK_GT:                   r = !f.z && (f.s == f.o);
      JK_GE:                   r = !f.c;
      JK_LT:                   r = (f.s != f.o);
      JK_LE:                   r = f.z || f.c;
      default:                 r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/br_flag_decode.sv
module br_flag_decode
  import br_pkg::*;
#(
  parameter int FW     = FLAG_W,
  parameter int Z_POS  = 0,
  parameter int C_POS  = 1,
  parameter int S_POS  = 2,
  parameter int O_POS  = 3
) (
  input  logic [FW-1:0] flags_i,
  output flagset_t      fs_o
);
  always_comb begin
    fs_o.z = flag_at(flags_i, Z_POS);
    fs_o.c = flag_at(flags_i, C_POS);
    fs_o.s = flag_at(flags_i, S_POS);
    fs_o.o = flag_at(flags_i, O_POS);
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  jkind_e   kind_i,
  input  flagset_t fs_i,
  output logic     taken_o,
  output logic     is_ret_o
);
  always_comb begin
    taken_o  = cond_holds(kind_i, fs_i);
    is_ret_o = (kind_i == JK_RET);
  end

  always_comb begin
    if (kind_i == JK_GE && fs_i.c)
      a_r4_ge_blocked_by_carry: assert (!taken_o);
    if (kind_i == JK_LE && fs_i.z)
      a_r6_le_on_zero: assert (taken_o);
    if (kind_i == JK_EQ && !fs_i.z)
      a_r1_eq_needs_zero: assert (!taken_o);
  end
endmodule

// File: rtl/br_target_sel.sv
module br_target_sel
  import br_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          taken_i,
  input  logic          is_ret_i,
  input  logic          use_acc_i,
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] imm_i,
  input  logic [AW-1:0] ret_i,
  input  logic [AW-1:0] seq_i,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] dest;

  always_comb begin
    if (is_ret_i)       dest = ret_i;
    else if (use_acc_i) dest = acc_i;
    else                dest = imm_i;
    next_o = taken_i ? dest : seq_i;
  end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int FW     = FLAG_W,
  parameter int Z_POS  = 0,
  parameter int C_POS  = 1,
  parameter int S_POS  = 2,
  parameter int O_POS  = 3
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic              use_acc_i,
  input  logic [FW-1:0]     flags_i,
  input  logic [AW-1:0]     acc_i,
  input  logic [AW-1:0]     seq_pc_i,
  input  logic [AW-1:0]     imm_i,
  input  logic [AW-1:0]     ret_addr_i,
  output logic [AW-1:0]     next_pc_o,
  output logic              taken_o
);
  jkind_e   kind;
  flagset_t fs;
  logic     cond_taken;
  logic     ret_sel;

  assign kind = jkind_e'(kind_i);

  br_flag_decode #(
    .FW(FW), .Z_POS(Z_POS), .C_POS(C_POS), .S_POS(S_POS), .O_POS(O_POS)
  ) u_flags (
    .flags_i (flags_i),
    .fs_o    (fs)
  );

  br_cond_eval u_cond (
    .kind_i   (kind),
    .fs_i     (fs),
    .taken_o  (cond_taken),
    .is_ret_o (ret_sel)
  );

  br_target_sel #(.AW(AW)) u_tgt (
    .taken_i   (cond_taken),
    .is_ret_i  (ret_sel),
    .use_acc_i (use_acc_i),
    .acc_i     (acc_i),
    .imm_i     (imm_i),
    .ret_i     (ret_addr_i),
    .seq_i     (seq_pc_i),
    .next_o    (next_pc_o)
  );

  assign taken_o = cond_taken;

  always_comb begin
    if (!cond_taken)
      a_r9_untaken_is_sequential: assert (next_pc_o == seq_pc_i);
    if (kind_i >= 4'd10 || kind_i == 4'd0)
      a_r10_no_jump_codes: assert (!taken_o);
    if (ret_sel)
      a_r7_return_target: assert (taken_o && next_pc_o == ret_addr_i);
    if (cond_taken && !ret_sel && !use_acc_i)
      a_r8_immediate_target: assert (next_pc_o == imm_i);
  end
endmodule

// File: tb/br_resolve_unit_tb_top.sv
module br_resolve_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]  kind;
  logic        use_acc;
  logic [7:0]  flags;
  logic [15:0] acc, seq_pc, imm, ret_addr;
  logic [15:0] next_pc;
  logic        taken;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  br_resolve_unit dut_i (
    .kind_i(kind), .use_acc_i(use_acc), .flags_i(flags), .acc_i(acc),
    .seq_pc_i(seq_pc), .imm_i(imm), .ret_addr_i(ret_addr),
    .next_pc_o(next_pc), .taken_o(taken)
  );

  function automatic string tag_of(input int k);
    case (k)
      1, 2, 3: return "R7";
      4: return "R1";
      5: return "R2";
      6: return "R3";
      7: return "R4";
      8: return "R5";
      9: return "R6";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference from the requirement list
  task automatic model(output bit t, output int pc);
    int zf = flags[0], cf = flags[1], sf = flags[2], ofl = flags[3];
    int k = kind;
    case (k)
      1, 2, 3: t = 1;
      4: t = (zf == 1);
      5: t = (zf == 0);
      6: t = (zf == 0) && (sf == ofl);
      7: t = (cf == 0);
      8: t = (sf != ofl);
      9: t = (zf == 1) || (cf == 1);
      default: t = 0;
    endcase
    if (!t) pc = seq_pc;
    else if (k == 3) pc = ret_addr;
    else if (use_acc) pc = acc;
    else pc = imm;
  endtask

  task automatic check(input string tag);
    bit et; int ep;
    model(et, ep);
    n_vec++;
    if (taken !== et || next_pc !== ep[15:0]) begin
      n_bad++;
      $display("FAIL %s kind=%0d form=%0d flags=%02h: got taken=%0b pc=%04h, expected taken=%0b pc=%04h",
               tag, kind, use_acc, flags, taken, next_pc, et, ep[15:0]);
    end
  endtask

  initial begin
    kind = 0; use_acc = 0; flags = 0;
    acc = 16'h1A1A; seq_pc = 16'h0203; imm = 16'hB0B0; ret_addr = 16'h7E7E;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle");
    // full sweep: every kind, both forms, all low-nibble flag combinations
    for (int k = 0; k < 16; k++)
      for (int f = 0; f < 2; f++)
        for (int fl = 0; fl < 16; fl++) begin
          @(posedge clk);
          kind = k[3:0]; use_acc = f[0];
          flags = {fl[3:0] ^ k[3:0], fl[3:0]};
          acc = 16'h4000 + 16'(k * 64 + fl);
          imm = 16'hC000 + 16'(k * 32 + fl * 2 + f);
          seq_pc = 16'h0100 + 16'(fl * 3);
          ret_addr = 16'h9000 + 16'(k + fl * 16);
          @(negedge clk);
          check((k >= 1 && k <= 9) ? (f ? "R8 acc" : "R8 imm") : tag_of(k));
          if (!taken) check("R9");
          else check(tag_of(k));
        end
    // R11: upper nibble flipped with lower nibble held
    for (int k = 4; k < 10; k++)
      for (int hi = 0; hi < 16; hi++) begin
        @(posedge clk);
        kind = k[3:0]; use_acc = hi[0];
        flags = {hi[3:0], 4'b0101};
        @(negedge clk);
        check("R11");
      end
    // R12: inputs change between edges, outputs follow without a clock
    @(posedge clk);
    #1 kind = 4'd7; flags = 8'h00; use_acc = 1'b0;
    #1 check("R12 ge");
    flags = 8'h02;
    #1 check("R12 ge carry");
    kind = 4'd3; use_acc = 1'b1;
    #1 check("R12 ret");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got running, expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule